// File: doc/BRIEF.md
# Byte Register File with Direct and Pointer Addressing

This block is the working storage of a byte-wide microcoded datapath. It holds 26 byte registers. A microinstruction can name a register in two ways. A direct 4-bit code selects one register outright. An indirect access goes through a 3-bit pair pointer plus a byte-select bit. The pointer is normally loaded from the register field of the macroinstruction that is being emulated, so the same microcode can work on whichever 16-bit register pair that instruction names.

The registers sit in even/odd pairs, and the even register of each pair is the low byte. Direct codes 2 to 15 reach fourteen registers. Twelve further registers can only be reached through the pointer. Pointer values 0 to 5 select the six pointer-only pairs. Pointer values 6 and 7 fold back onto the upper direct pairs: value 6 selects codes 14/15 and value 7 selects codes 12/13. Because of this fold, microcode can hand two macro-level registers to the same storage that it also names directly.

The block has two independent combinational read ports, each with a word mode that returns a whole pair. It has one synchronous byte write port and a synchronously loaded pointer.

Top module: `brf_regfile`

## Requirements
- R1: When `rst` is high at a clock edge, every register and the pointer become 0.
- R2: A direct read with a code from 2 to 15 returns the register for that code. Each of these codes names a distinct register. Codes 0 and 1 read as 0.
- R3: A direct write with code 0 or 1 changes no register.
- R4: An indirect access with pointer p from 0 to 5 reaches pointer-only register 2p (byte select 0) or 2p+1 (byte select 1). These twelve registers are distinct from every register that direct codes reach.
- R5: An indirect access with pointer 6 reaches the register of direct code 14 (byte select 0) or code 15 (byte select 1). With pointer 7 it reaches code 12 or code 13.
- R6: A write takes effect at the clock edge. A read in the same cycle as a write to the same register returns the old value, and the new value appears from the next cycle on.
- R7: The pointer takes `ptr_in` at an edge where `ptr_ld` is high and otherwise holds its value. `ptr_q` shows the pointer.
- R8: In word mode a read port returns {odd byte, even byte} of a pair. For a direct read the pair is chosen with address bit 0 ignored, and for an indirect read the byte select is ignored. In byte mode bits 15:8 of the port are 0 and bits 7:0 hold the selected byte.
- R9: The two read ports are independent and may read different registers in the same cycle.
- R10: An indirect write uses the pointer value that holds before the edge, even when the pointer loads at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_ld | input | 1 | Load enable for the pair pointer |
| ptr_in | input | 3 | New pointer value |
| ptr_q | output | 3 | Current pointer value |
| we | input | 1 | Write enable |
| w_ind | input | 1 | Write through the pointer (1) or direct code (0) |
| w_addr | input | 4 | Direct write code |
| w_hi | input | 1 | Byte select for an indirect write (1 = odd byte) |
| w_data | input | 8 | Write data |
| a_ind | input | 1 | Port A indirect select |
| a_addr | input | 4 | Port A direct code |
| a_hi | input | 1 | Port A indirect byte select |
| a_word | input | 1 | Port A word mode |
| a_data | output | 16 | Port A read data |
| b_ind | input | 1 | Port B indirect select |
| b_addr | input | 4 | Port B direct code |
| b_hi | input | 1 | Port B indirect byte select |
| b_word | input | 1 | Port B word mode |
| b_data | output | 16 | Port B read data |

## Verification
The bench fills every direct code and every pointer pair with distinct values, then reads all of them back through both address spaces. A decoder that maps the pointer linearly onto the file would corrupt a direct register here, and a wrong fold would show up as a mismatch at codes 12 to 15. Writes to codes 0 and 1 are checked so that a decoder which wraps those codes onto real storage shows up as a changed register. The bench also checks a same-cycle read and write, where a forwarding path would return the new byte too early, and a write in the cycle the pointer loads, where a design that uses the new pointer writes the wrong pair. Word reads at odd direct codes catch a design that does not ignore address bit 0.

// File: rtl/brf_pkg.sv
package brf_pkg;

    parameter int BYTE_W          = 8;
    parameter int NUM_DIRECT_ONLY = 10;
    parameter int NUM_SHARED      = 4;
    parameter int NUM_IND_ONLY    = 12;
    parameter int PTR_W           = 3;
    parameter int DADDR_W         = 4;
    parameter int FIRST_CODE      = 2;

    localparam int NUM_REGS       = NUM_DIRECT_ONLY + NUM_SHARED + NUM_IND_ONLY;
    localparam int IDX_W          = $clog2(NUM_REGS);
    localparam int IND_PAIRS      = NUM_IND_ONLY / 2;
    localparam int SHARED_PAIRS   = NUM_SHARED / 2;
    localparam int IND_BASE       = NUM_DIRECT_ONLY + NUM_SHARED;
    localparam int WORD_W         = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [PTR_W-1:0]   ptr_t;
    typedef logic [DADDR_W-1:0] daddr_t;

    // Physical location of one byte; hit low means no storage behind it.
    typedef struct packed {
        logic hit;
        idx_t idx;
    } slot_t;

    // Addressing request of one port.
    typedef struct packed {
        logic   ind;
        daddr_t addr;
        logic   hi;
    } req_t;

    // Direct code to physical slot: codes below FIRST_CODE have no storage.
    function automatic slot_t direct_slot(input daddr_t code);
        slot_t s;
        if (int'(code) < FIRST_CODE) begin
            s.hit = 1'b0;
            s.idx = '0;
        end else begin
            s.hit = 1'b1;
            s.idx = idx_t'(int'(code) - FIRST_CODE);
        end
        return s;
    endfunction

    // Pointer plus byte select to physical slot. Low pointer values reach the
    // pointer-only pairs in order; the remaining values fold onto the shared
    // direct pairs, walking them from the top down.
    function automatic slot_t pointer_slot(input ptr_t p, input logic hi);
        slot_t s;
        int    sp;
        s.hit = 1'b1;
        if (int'(p) < IND_PAIRS) begin
            s.idx = idx_t'(IND_BASE + 2 * int'(p) + int'(hi));
        end else begin
            sp    = SHARED_PAIRS - 1 - (int'(p) - IND_PAIRS);
            s.idx = idx_t'(NUM_DIRECT_ONLY + 2 * sp + int'(hi));
        end
        return s;
    endfunction

endpackage

// File: rtl/brf_ptr_reg.sv
module brf_ptr_reg
    import brf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  ptr_t din,
    output ptr_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q <= din;
        end
    end

endmodule

// File: rtl/brf_locate.sv
module brf_locate
    import brf_pkg::*;
(
    input  req_t  req,
    input  ptr_t  ptr,
    output slot_t lo_slot,
    output slot_t hi_slot,
    output logic  pick_hi
);

    daddr_t even_code;
    daddr_t odd_code;

    always_comb begin
        even_code = {req.addr[DADDR_W-1:1], 1'b0};
        odd_code  = {req.addr[DADDR_W-1:1], 1'b1};
        if (req.ind) begin
            lo_slot = pointer_slot(ptr, 1'b0);
            hi_slot = pointer_slot(ptr, 1'b1);
            pick_hi = req.hi;
        end else begin
            lo_slot = direct_slot(even_code);
            hi_slot = direct_slot(odd_code);
            pick_hi = req.addr[0];
        end
    end

endmodule

// File: rtl/brf_store.sv
module brf_store
    import brf_pkg::*;
#(
    parameter int NRD = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  slot_t               w_slot,
    input  byte_t               w_data,
    input  slot_t [NRD-1:0]     rd_slot,
    output byte_t [NRD-1:0]     rd_data
);

    byte_t mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (we && w_slot.hit) begin
            mem[w_slot.idx] <= w_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = rd_slot[g].hit ? mem[rd_slot[g].idx] : '0;
    end

endmodule

// File: rtl/brf_regfile.sv
module brf_regfile
    import brf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ptr_ld,
    input  logic [2:0]  ptr_in,
    output logic [2:0]  ptr_q,
    input  logic        we,
    input  logic        w_ind,
    input  logic [3:0]  w_addr,
    input  logic        w_hi,
    input  logic [7:0]  w_data,
    input  logic        a_ind,
    input  logic [3:0]  a_addr,
    input  logic        a_hi,
    input  logic        a_word,
    output logic [15:0] a_data,
    input  logic        b_ind,
    input  logic [3:0]  b_addr,
    input  logic        b_hi,
    input  logic        b_word,
    output logic [15:0] b_data
);

    localparam int NPORT = 2;
    localparam int NREQ  = NPORT + 1;
    localparam int WIDX  = NPORT;
    localparam int NRD   = 2 * NPORT;

    ptr_t                ptr_cur;
    req_t  [NREQ-1:0]    req;
    logic  [NPORT-1:0]   word_mode;
    slot_t [NREQ-1:0]    lo_s;
    slot_t [NREQ-1:0]    hi_s;
    logic  [NREQ-1:0]    pick_hi;
    slot_t [NRD-1:0]     rd_s;
    byte_t [NRD-1:0]     rd_b;
    word_t [NPORT-1:0]   port_out;
    slot_t               w_slot;

    brf_ptr_reg u_ptr (
        .clk (clk),
        .rst (rst),
        .ld  (ptr_ld),
        .din (ptr_in),
        .q   (ptr_cur)
    );

    assign ptr_q = ptr_cur;

    always_comb begin
        req[0].ind    = a_ind;
        req[0].addr   = a_addr;
        req[0].hi     = a_hi;
        req[1].ind    = b_ind;
        req[1].addr   = b_addr;
        req[1].hi     = b_hi;
        req[WIDX].ind  = w_ind;
        req[WIDX].addr = w_addr;
        req[WIDX].hi   = w_hi;
        word_mode     = {b_word, a_word};
    end

    for (genvar g = 0; g < NREQ; g++) begin : g_loc
        brf_locate u_loc (
            .req     (req[g]),
            .ptr     (ptr_cur),
            .lo_slot (lo_s[g]),
            .hi_slot (hi_s[g]),
            .pick_hi (pick_hi[g])
        );
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign rd_s[2*g]     = lo_s[g];
        assign rd_s[2*g + 1] = hi_s[g];
        assign port_out[g]   = word_mode[g] ? {rd_b[2*g + 1], rd_b[2*g]}
                             : {{BYTE_W{1'b0}}, (pick_hi[g] ? rd_b[2*g + 1] : rd_b[2*g])};
    end

    assign w_slot = pick_hi[WIDX] ? hi_s[WIDX] : lo_s[WIDX];

    brf_store #(.NRD(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .w_slot  (w_slot),
        .w_data  (w_data),
        .rd_slot (rd_s),
        .rd_data (rd_b)
    );

    assign a_data = port_out[0];
    assign b_data = port_out[1];

endmodule

// File: rtl/brf_checker.sv
module brf_checker (
    input logic        clk,
    input logic        rst,
    input logic        ptr_ld,
    input logic [2:0]  ptr_in,
    input logic [2:0]  ptr_q,
    input logic        we,
    input logic        w_ind,
    input logic [3:0]  w_addr,
    input logic [7:0]  w_data,
    input logic        a_ind,
    input logic [3:0]  a_addr,
    input logic        a_hi,
    input logic        a_word,
    input logic [15:0] a_data,
    input logic        b_ind,
    input logic [3:0]  b_addr,
    input logic        b_hi,
    input logic        b_word,
    input logic [15:0] b_data
);

    p_ptr_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ptr_q == 3'd0);

    p_ptr_load_r7: assert property (@(posedge clk) disable iff (rst)
        ptr_ld |=> ptr_q == $past(ptr_in));

    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ptr_ld |=> $stable(ptr_q));

    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!a_ind && !a_word && a_addr < 4'd2) |-> a_data == 16'h0000);

    p_fold_r5: assert property (@(posedge clk) disable iff (rst)
        (a_ind && !a_word && !a_hi && ptr_q == 3'd6 && !b_ind && !b_word && b_addr == 4'd14)
        |-> a_data == b_data);

    p_word_hi_r8: assert property (@(posedge clk) disable iff (rst)
        (a_ind && a_word && b_ind && !b_word && b_hi) |-> a_data[15:8] == b_data[7:0]);

    p_byte_upper_r8: assert property (@(posedge clk) disable iff (rst)
        !b_word |-> b_data[15:8] == 8'h00);

    p_write_seen_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(we && !w_ind && w_addr >= 4'd2) && !$past(rst)
         && !a_ind && !a_word && a_addr == $past(w_addr))
        |-> a_data[7:0] == $past(w_data));

endmodule

bind brf_regfile brf_checker chk_i (
    .clk    (clk),
    .rst    (rst),
    .ptr_ld (ptr_ld),
    .ptr_in (ptr_in),
    .ptr_q  (ptr_q),
    .we     (we),
    .w_ind  (w_ind),
    .w_addr (w_addr),
    .w_data (w_data),
    .a_ind  (a_ind),
    .a_addr (a_addr),
    .a_hi   (a_hi),
    .a_word (a_word),
    .a_data (a_data),
    .b_ind  (b_ind),
    .b_addr (b_addr),
    .b_hi   (b_hi),
    .b_word (b_word),
    .b_data (b_data)
);

// File: tb/brf_regfile_tb_top.sv
`timescale 1ns/1ps
module brf_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ptr_ld;
    logic [2:0]  ptr_in;
    logic [2:0]  ptr_q;
    logic        we;
    logic        w_ind;
    logic [3:0]  w_addr;
    logic        w_hi;
    logic [7:0]  w_data;
    logic        a_ind;
    logic [3:0]  a_addr;
    logic        a_hi;
    logic        a_word;
    logic [15:0] a_data;
    logic        b_ind;
    logic [3:0]  b_addr;
    logic        b_hi;
    logic        b_word;
    logic [15:0] b_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] dmod [16];
    logic [7:0] gmod [12];

    always #2 clk = ~clk;

    brf_regfile dut_i (.*);

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] ind_exp(input int p, input int hi);
        if (p < 6) return gmod[2*p + hi];
        else if (p == 6) return dmod[14 + hi];
        else return dmod[12 + hi];
    endfunction

    task automatic idle();
        we = 0; w_ind = 0; w_addr = 0; w_hi = 0; w_data = 0; ptr_ld = 0; ptr_in = 0;
        a_ind = 0; a_addr = 0; a_hi = 0; a_word = 0;
        b_ind = 0; b_addr = 0; b_hi = 0; b_word = 0;
    endtask

    task automatic wr_dir(input int code, input logic [7:0] v);
        @(negedge clk);
        we = 1; w_ind = 0; w_addr = 4'(code); w_data = v;
        @(negedge clk);
        we = 0;
        if (code >= 2) dmod[code] = v;
    endtask

    task automatic wr_ind(input int hi, input logic [7:0] v);
        int p;
        @(negedge clk);
        p = int'(ptr_q);
        we = 1; w_ind = 1; w_hi = 1'(hi); w_data = v;
        @(negedge clk);
        we = 0;
        if (p < 6) gmod[2*p + hi] = v;
        else if (p == 6) dmod[14 + hi] = v;
        else dmod[12 + hi] = v;
    endtask

    task automatic ld_ptr(input int p);
        @(negedge clk);
        ptr_ld = 1; ptr_in = 3'(p);
        @(negedge clk);
        ptr_ld = 0;
    endtask

    task automatic rd_a(input logic ind, input int addr, input int hi, input logic word,
                        output logic [15:0] d);
        @(negedge clk);
        a_ind = ind; a_addr = 4'(addr); a_hi = 1'(hi); a_word = word;
        #1 d = a_data;
    endtask

    task automatic sweep(input string req);
        logic [15:0] d;
        for (int c = 0; c < 16; c++) begin
            rd_a(0, c, 0, 0, d);
            check(req, d, (c < 2) ? 16'h0 : {8'h00, dmod[c]});
        end
        for (int p = 0; p < 8; p++) begin
            ld_ptr(p);
            for (int h = 0; h < 2; h++) begin
                rd_a(1, 0, h, 0, d);
                check(req, d, {8'h00, ind_exp(p, h)});
            end
        end
    endtask

    task automatic t_reset();
        check("R1 ptr", {13'h0, ptr_q}, 16'h0);
        sweep("R1 reset contents");
    endtask

    task automatic t_direct();
        for (int c = 0; c < 16; c++) wr_dir(c, 8'(8'h30 + c));
        sweep("R2 R3 direct fill");
    endtask

    task automatic t_indirect();
        for (int p = 0; p < 6; p++) begin
            ld_ptr(p);
            wr_ind(0, 8'(8'hA0 + 2*p));
            wr_ind(1, 8'(8'hA1 + 2*p));
        end
        sweep("R4 pointer pairs");
    endtask

    task automatic t_fold();
        logic [15:0] d;
        ld_ptr(6);
        wr_ind(0, 8'h5E);
        wr_ind(1, 8'h5F);
        rd_a(0, 14, 0, 0, d); check("R5 ptr6 lo -> code14", d, 16'h005E);
        rd_a(0, 15, 0, 0, d); check("R5 ptr6 hi -> code15", d, 16'h005F);
        ld_ptr(7);
        wr_ind(1, 8'h7D);
        rd_a(0, 13, 0, 0, d); check("R5 ptr7 hi -> code13", d, 16'h007D);
        wr_dir(12, 8'hC2);
        rd_a(1, 0, 0, 0, d); check("R5 code12 -> ptr7 lo", d, 16'h00C2);
        sweep("R5 fold sweep");
    endtask

    task automatic t_rdw();
        logic [15:0] d;
        @(negedge clk);
        we = 1; w_ind = 0; w_addr = 4'd5; w_data = 8'hE5;
        a_ind = 0; a_addr = 4'd5; a_word = 0;
        #1 check("R6 same-cycle old value", a_data, {8'h00, dmod[5]});
        @(negedge clk);
        we = 0;
        dmod[5] = 8'hE5;
        #1 check("R6 next-cycle new value", a_data, 16'h00E5);
        rd_a(0, 5, 0, 0, d);
        check("R6 holds", d, 16'h00E5);
    endtask

    task automatic t_ptr();
        ld_ptr(3);
        check("R7 load", {13'h0, ptr_q}, 16'h3);
        @(negedge clk);
        ptr_in = 3'd5;
        @(negedge clk);
        check("R7 hold without load", {13'h0, ptr_q}, 16'h3);
    endtask

    task automatic t_same_edge();
        logic [15:0] d;
        ld_ptr(1);
        @(negedge clk);
        ptr_ld = 1; ptr_in = 3'd4;
        we = 1; w_ind = 1; w_hi = 0; w_data = 8'h77;
        @(negedge clk);
        ptr_ld = 0; we = 0;
        gmod[2] = 8'h77;
        check("R10 pointer updated", {13'h0, ptr_q}, 16'h4);
        rd_a(1, 0, 0, 0, d); check("R10 new pair untouched", d, {8'h00, gmod[8]});
        ld_ptr(1);
        rd_a(1, 0, 0, 0, d); check("R10 old pair written", d, 16'h0077);
    endtask

    task automatic t_word();
        logic [15:0] d;
        ld_ptr(2);
        rd_a(1, 0, 0, 1, d); check("R8 indirect word", d, {gmod[5], gmod[4]});
        rd_a(1, 0, 1, 1, d); check("R8 byte select ignored", d, {gmod[5], gmod[4]});
        rd_a(0, 5, 0, 1, d); check("R8 direct odd code word", d, {dmod[5], dmod[4]});
        rd_a(0, 4, 0, 1, d); check("R8 direct even code word", d, {dmod[5], dmod[4]});
        rd_a(0, 1, 0, 1, d); check("R8 unimplemented pair word", d, 16'h0000);
        rd_a(0, 9, 0, 0, d); check("R8 byte mode upper zero", d, {8'h00, dmod[9]});
    endtask

    task automatic t_dual();
        ld_ptr(0);
        @(negedge clk);
        a_ind = 0; a_addr = 4'd7;  a_word = 0;
        b_ind = 1; b_hi = 1; b_word = 0;
        #1;
        check("R9 port A", a_data, {8'h00, dmod[7]});
        check("R9 port B", b_data, {8'h00, gmod[1]});
        @(negedge clk);
        b_ind = 0; b_addr = 4'd11; b_word = 1;
        a_ind = 1; a_hi = 0; a_word = 0;
        #1;
        check("R9 port B word", b_data, {dmod[11], dmod[10]});
        check("R9 port A indirect", a_data, {8'h00, gmod[0]});
    endtask

    initial begin
        for (int i = 0; i < 16; i++) dmod[i] = 8'h00;
        for (int i = 0; i < 12; i++) gmod[i] = 8'h00;
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_direct();
        t_indirect();
        t_fold();
        t_rdw();
        t_ptr();
        t_same_edge();
        t_word();
        t_dual();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule